// File: doc/BRIEF.md
# SPI Status and Interrupt Front End

This block sits beside the data path of a serial peripheral interface and turns its buffer events into status flags, one interrupt line and two DMA request strobes. It watches the moment the transmit buffer is handed to the shift register and the moment a received word lands in the receive buffer. From these it keeps three sticky flags: transmit-empty, receive-full and receive-overrun. Each flag has its own enable bit. A software-set manual request bit can raise the interrupt line on its own.

Software reaches a status register and an interrupt control register over a small single-cycle register bus. The data path reports two further strobes: a write of the transmit buffer and a read of the receive buffer. These strobes clear the transmit-empty and receive-full flags. The same events that set those two flags also drive the transmit and receive DMA requests.

Top module: `spi_irq_front`

## Requirements
- R1: After reset, every flag, every enable and the manual bit are 0, irq is 0, both DMA requests are 0, and both registers read as 0.
- R2: Transmit-empty is bit 4 of the status register (reg_addr=0). It becomes 1 on the clock edge after a tx_xfer pulse. It becomes 0 on the edge after a txbuf_wr. If both strobes come in the same cycle, txbuf_wr wins and the flag ends at 0.
- R3: Receive-full is bit 2 of the status register. It becomes 1 on the edge after rx_load. It becomes 0 on the edge after rxbuf_rd. If both strobes come in the same cycle, rx_load wins and the flag ends at 1.
- R4: Overrun is bit 3 of the status register. It becomes 1 when rx_load arrives while receive-full is already 1 and rxbuf_rd is not active in that cycle. A read in the same cycle as the load prevents the overrun.
- R5: Writing to address 0 with data bit 3 set clears overrun. If the overrun condition occurs in the same cycle, overrun stays at 1. All other bits written to address 0 have no effect.
- R6: The interrupt control register at reg_addr=1 holds these bits, which read back as written: transmit-empty enable at bit 4, overrun enable at bit 3, receive-full enable at bit 2, manual request at bit 1. Its other bits read as 0.
- R7: The flags set and clear the same way whatever the enables hold.
- R8: irq is the OR of the manual bit and of each flag ANDed with its enable. It is a level that follows register state, so it changes on the edge that updates that state.
- R9: tx_dma_req and rx_dma_req are one-cycle pulses. Each is high in the cycle after tx_xfer or rx_load, the same cycle in which the matching flag first shows as 1.
- R10: Unused bits of the status register read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 1 | Register select: 0 status, 1 interrupt control |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data of the selected register, combinational |
| tx_xfer | input | 1 | Transmit buffer moved into the shift register |
| txbuf_wr | input | 1 | Software wrote the transmit buffer |
| rx_load | input | 1 | Shift register contents loaded into the receive buffer |
| rxbuf_rd | input | 1 | Software read the receive buffer |
| irq | output | 1 | Level-sensitive interrupt request |
| tx_dma_req | output | 1 | Transmit DMA request pulse |
| rx_dma_req | output | 1 | Receive DMA request pulse |

## Verification
The critical collision is a receive load in the same cycle as a receive buffer read. It decides between keeping receive-full and raising overrun. A transfer that coincides with a transmit buffer write, and an overrun clear that meets a new overrun, are the related cases. The bench steps through every combination of the four data-path strobes together with register writes to either address. Since the flags carry over from step to step, each collision is met with the flags both set and clear. After each step a bench-side model derived from R2 to R5 predicts the status, control, irq and DMA values.

// File: rtl/spi_irq_front.sv
module spi_irq_front #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_addr,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          tx_xfer,
  input  logic          txbuf_wr,
  input  logic          rx_load,
  input  logic          rxbuf_rd,
  output logic          irq,
  output logic          tx_dma_req,
  output logic          rx_dma_req
);
  localparam int B_TXE = 4;
  localparam int B_OVF = 3;
  localparam int B_RXF = 2;
  localparam int B_MAN = 1;

  logic txe_q, rxf_q, ovf_q;
  logic ie_txe_q, ie_ovf_q, ie_rxf_q, man_q;

  wire sts_wr  = reg_wr && !reg_addr;
  wire ctl_wr  = reg_wr && reg_addr;
  wire ovf_set = rx_load && rxf_q && !rxbuf_rd;
  wire ovf_clr = sts_wr && reg_wdata[B_OVF];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txe_q      <= 1'b0;
      rxf_q      <= 1'b0;
      ovf_q      <= 1'b0;
      ie_txe_q   <= 1'b0;
      ie_ovf_q   <= 1'b0;
      ie_rxf_q   <= 1'b0;
      man_q      <= 1'b0;
      tx_dma_req <= 1'b0;
      rx_dma_req <= 1'b0;
    end else begin
      if (txbuf_wr)     txe_q <= 1'b0;
      else if (tx_xfer) txe_q <= 1'b1;
      if (rx_load)       rxf_q <= 1'b1;
      else if (rxbuf_rd) rxf_q <= 1'b0;
      if (ovf_set)      ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;
      if (ctl_wr) begin
        ie_txe_q <= reg_wdata[B_TXE];
        ie_ovf_q <= reg_wdata[B_OVF];
        ie_rxf_q <= reg_wdata[B_RXF];
        man_q    <= reg_wdata[B_MAN];
      end
      tx_dma_req <= tx_xfer;
      rx_dma_req <= rx_load;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr) begin
      reg_rdata[B_TXE] = ie_txe_q;
      reg_rdata[B_OVF] = ie_ovf_q;
      reg_rdata[B_RXF] = ie_rxf_q;
      reg_rdata[B_MAN] = man_q;
    end else begin
      reg_rdata[B_TXE] = txe_q;
      reg_rdata[B_OVF] = ovf_q;
      reg_rdata[B_RXF] = rxf_q;
    end
  end

  assign irq = man_q | (txe_q & ie_txe_q) | (ovf_q & ie_ovf_q) | (rxf_q & ie_rxf_q);
endmodule

// File: rtl/spi_irq_front_chk.sv
module spi_irq_front_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_addr,
  input logic          reg_wr,
  input logic [DW-1:0] reg_wdata,
  input logic          tx_xfer,
  input logic          txbuf_wr,
  input logic          rx_load,
  input logic          rxbuf_rd,
  input logic          irq,
  input logic          tx_dma_req,
  input logic          rx_dma_req,
  input logic          txe_q,
  input logic          rxf_q,
  input logic          ovf_q
);
  AST_TXE_SET: assert property (@(posedge clk) disable iff (!rst_n) tx_xfer && !txbuf_wr |=> txe_q); // R2
  AST_TXE_CLR: assert property (@(posedge clk) disable iff (!rst_n) txbuf_wr |=> !txe_q); // R2
  AST_RXF_SET: assert property (@(posedge clk) disable iff (!rst_n) rx_load |=> rxf_q); // R3
  AST_RXF_CLR: assert property (@(posedge clk) disable iff (!rst_n) rxbuf_rd && !rx_load |=> !rxf_q); // R3
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n) rx_load && rxf_q && !rxbuf_rd |=> ovf_q); // R4
  AST_OVF_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && !reg_addr && reg_wdata[3] && !(rx_load && rxf_q && !rxbuf_rd) |=> !ovf_q); // R5
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(reg_wr || tx_xfer || rx_load)); // R8
  AST_TXDMA_ON: assert property (@(posedge clk) disable iff (!rst_n) tx_xfer |=> tx_dma_req); // R9
  AST_TXDMA_OFF: assert property (@(posedge clk) disable iff (!rst_n) !tx_xfer |=> !tx_dma_req); // R9
  AST_RXDMA_ON: assert property (@(posedge clk) disable iff (!rst_n) rx_load |=> rx_dma_req); // R9
  AST_RXDMA_OFF: assert property (@(posedge clk) disable iff (!rst_n) !rx_load |=> !rx_dma_req); // R9
endmodule

bind spi_irq_front spi_irq_front_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .tx_xfer(tx_xfer), .txbuf_wr(txbuf_wr), .rx_load(rx_load), .rxbuf_rd(rxbuf_rd),
  .irq(irq), .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req),
  .txe_q(txe_q), .rxf_q(rxf_q), .ovf_q(ovf_q)
);

// File: tb/spi_irq_front_tb.sv
module spi_irq_front_tb;
  localparam int DW = 8;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_addr = 1'b0, reg_wr = 1'b0;
  logic [DW-1:0] reg_wdata = '0, reg_rdata;
  logic tx_xfer = 1'b0, txbuf_wr = 1'b0, rx_load = 1'b0, rxbuf_rd = 1'b0;
  logic irq, tx_dma_req, rx_dma_req;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic m_te = 0, m_rf = 0, m_ov = 0, m_ite = 0, m_iov = 0, m_irf = 0, m_man = 0;

  spi_irq_front #(.DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tx_xfer(tx_xfer), .txbuf_wr(txbuf_wr), .rx_load(rx_load),
    .rxbuf_rd(rxbuf_rd), .irq(irq), .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] exp_sts();
    logic [DW-1:0] v = '0;
    v[4] = m_te; v[3] = m_ov; v[2] = m_rf;
    return v;
  endfunction

  function automatic logic [DW-1:0] exp_ctl();
    logic [DW-1:0] v = '0;
    v[4] = m_ite; v[3] = m_iov; v[2] = m_irf; v[1] = m_man;
    return v;
  endfunction

  task automatic observe(input string tag, input logic etx, input logic erx);
    reg_addr = 1'b0; #1;
    chk({tag, " R2 R3 R4 R5 R10 status"}, reg_rdata, exp_sts());
    reg_addr = 1'b1; #1;
    chk({tag, " R6 control"}, reg_rdata, exp_ctl());
    reg_addr = 1'b0; #1;
    chk({tag, " R8 irq"}, irq, m_man | (m_te & m_ite) | (m_ov & m_iov) | (m_rf & m_irf));
    chk({tag, " R9 tx dma"}, tx_dma_req, etx);
    chk({tag, " R9 rx dma"}, rx_dma_req, erx);
  endtask

  task automatic step(input logic tev, input logic twr, input logic rev, input logic rrd,
                      input logic wr, input logic adr, input logic [DW-1:0] wd);
    logic ov_set;
    tx_xfer = tev; txbuf_wr = twr; rx_load = rev; rxbuf_rd = rrd;
    reg_wr = wr; reg_addr = adr; reg_wdata = wd;
    ov_set = rev && m_rf && !rrd;
    if (twr) m_te = 0; else if (tev) m_te = 1;
    if (ov_set) m_ov = 1; else if (wr && !adr && wd[3]) m_ov = 0;
    if (rev) m_rf = 1; else if (rrd) m_rf = 0;
    if (wr && adr) begin m_ite = wd[4]; m_iov = wd[3]; m_irf = wd[2]; m_man = wd[1]; end
    @(posedge clk);
    @(negedge clk);
    tx_xfer = 0; txbuf_wr = 0; rx_load = 0; rxbuf_rd = 0; reg_wr = 0;
    observe("step", tev, rev);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    observe("R1 reset", 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    observe("R1 after release", 1'b0, 1'b0);

    // R4 same-cycle read protects against overrun; R3 load wins over read
    step(0, 0, 1, 0, 0, 0, '0);
    step(0, 0, 1, 1, 0, 0, '0);
    chk("R4 load with read no overrun", m_ov, 1'b0);
    step(0, 0, 1, 0, 0, 0, '0);
    // R5 set beats clear; R7 flags with enables off
    step(0, 0, 1, 0, 1, 0, 8'hFF);
    chk("R5 set wins over clear", m_ov, 1'b1);
    // R2 write wins over transfer
    step(1, 1, 0, 0, 0, 0, '0);

    // exhaustive sweep over strobes, write target and control/status data bits
    for (int i = 0; i < 2048; i++) begin
      logic [DW-1:0] wd;
      wd = '0;
      wd[4:1] = i[9:6];
      wd[7]   = i[10];
      wd[0]   = i[10];
      step(i[0], i[1], i[2], i[3], i[4], i[5], wd);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule